// File: doc/BRIEF.md
# Twisted-Ring Step Counter with Two-Input Decode

This block is a synchronous twisted-ring counter built from a parameterised number of flip-flops, `STAGES`. On each enabled clock edge the register shifts one place toward bit 0. The complement of bit 0 enters at the top. The counter therefore walks through `2*STAGES` states before it repeats. A decoder in the same block turns the state into a one-hot vector with one line per count. Each line is a single two-input AND of state bits, so the decode depth is the same at every width.

A user holds `en` high to advance one step per clock, or low to freeze the count. The raw state and the decoded line are both visible at the outputs. Patterns that are not part of the sequence cannot arise after reset. If one appears anyway, the next enabled edge replaces it with all zeros, and the sequence resumes from there.

The block carries no data stream, so it has no valid/ready handshake. All pins are plain control and status pins, and nothing at the edge applies back-pressure.

Top module: `twist_ring_decode`

## Requirements
- R1: While `rst` is high at a rising edge, the state becomes all zeros. After that edge, `hot` equals 1 (only line 0 high).
- R2: At a rising edge with `rst` low and `en` high, and a legal state, the next state is `{~state[0], state[STAGES-1:1]}`.
- R3: For STAGES=4 the states from reset are 0000, 1000, 1100, 1110, 1111, 0111, 0011, 0001 (bit 3 written first). The sequence then repeats, so the period is 2*STAGES enabled edges.
- R4: At a rising edge with `rst` low and `en` low, the state does not change.
- R5: In every legal state exactly one bit of `hot` is high. That bit is `hot[k]`, where k is the number of enabled edges since reset, modulo 2*STAGES.
- R6: Each `hot[k]` is a two-input AND of state bits:
  - line 0 uses ~s[S-1] and ~s[0];
  - line k, for 1 ≤ k < S, uses s[S-k] and ~s[S-k-1];
  - line S uses s[S-1] and s[0];
  - line S+j, for 1 ≤ j < S, uses ~s[S-j] and s[S-j-1].
  Here S is STAGES.
- R7: The block works for any STAGES of 2 or more, with `hot` 2*STAGES bits wide.
- R8: A legal state has at most one position where adjacent bits differ. `state` is always legal. An illegal state is replaced by all zeros at the next enabled edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance one step when high, hold when low |
| state | output | STAGES | Raw flip-flop contents |
| hot | output | 2*STAGES | One-hot decoded count |

## Verification
The bench builds two instances side by side: one with STAGES=4 and one with STAGES=5. Both are driven by a shared enable pattern with long runs of holds and advances. With the small state spaces of 8 and 10 counts, every count and every wrap back to zero is visited many times. Expected state and decoded line are computed arithmetically from the bench's own count of enabled edges. The odd width checks that the decode formulas do not rely on an even number of stages. A reset in the middle of the run shows the return to count 0 from an arbitrary point.

// File: rtl/twr_pkg.sv
package twr_pkg;
  function automatic int ring_len(input int stages);
    return 2 * stages;
  endfunction
endpackage

// File: rtl/twr_next.sv
module twr_next #(
  parameter int STAGES = 4
) (
  input  logic [STAGES-1:0] cur,
  output logic [STAGES-1:0] nxt,
  output logic              legal
);
  localparam int EDGES = STAGES - 1;

  logic [EDGES-1:0] diff;
  int               n_diff;

  assign diff = cur[STAGES-1:1] ^ cur[STAGES-2:0];

  always_comb begin
    n_diff = 0;
    for (int i = 0; i < EDGES; i++) n_diff += int'(diff[i]);
  end

  assign legal = (n_diff <= 1);
  assign nxt   = legal ? {~cur[0], cur[STAGES-1:1]} : '0;
endmodule

// File: rtl/twr_decode.sv
module twr_decode #(
  parameter int STAGES = 4
) (
  input  logic [STAGES-1:0]   s,
  output logic [2*STAGES-1:0] line
);
  localparam int LINES = 2 * STAGES;

  for (genvar k = 0; k < LINES; k++) begin : g_line
    if (k == 0) begin : g_zero
      assign line[k] = ~s[STAGES-1] & ~s[0];
    end else if (k < STAGES) begin : g_fill
      assign line[k] = s[STAGES-k] & ~s[STAGES-k-1];
    end else if (k == STAGES) begin : g_full
      assign line[k] = s[STAGES-1] & s[0];
    end else begin : g_drain
      assign line[k] = ~s[2*STAGES-k] & s[2*STAGES-k-1];
    end
  end
endmodule

// File: rtl/twist_ring_decode.sv
module twist_ring_decode #(
  parameter int STAGES = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en,
  output logic [STAGES-1:0]         state,
  output logic [2*STAGES-1:0]       hot
);
  import twr_pkg::*;
  localparam int LINES = ring_len(STAGES);

  logic [STAGES-1:0] q, q_nxt;
  logic              q_legal;

  twr_next #(.STAGES(STAGES)) next_i (
    .cur(q), .nxt(q_nxt), .legal(q_legal)
  );

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= q_nxt;
  end

  twr_decode #(.STAGES(STAGES)) dec_i (
    .s(q), .line(hot)
  );

  assign state = q;

  initial assert (STAGES >= 2 && LINES == 2 * STAGES); // R7

  AST_ALWAYS_LEGAL: assert property (@(posedge clk) disable iff (rst)
    q_legal); // R8
  AST_ONE_LINE: assert property (@(posedge clk) disable iff (rst)
    $countones(hot) == 1); // R5
  AST_HOLD_STILL: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(state)); // R4
  AST_STEP_MOVES: assert property (@(posedge clk) disable iff (rst)
    en |=> state != $past(state)); // R2
  AST_LINE_MOVES: assert property (@(posedge clk) disable iff (rst)
    en |=> hot != $past(hot)); // R6
endmodule

// File: tb/twist_ring_decode_tb_top.sv
module twist_ring_decode_tb_top;
  logic clk = 0;
  logic rst = 1;
  logic en  = 0;
  logic [3:0] st4;
  logic [7:0] hot4;
  logic [4:0] st5;
  logic [9:0] hot5;
  int checks = 0, fails = 0;
  int k4 = 0, k5 = 0;

  always #2 clk = ~clk;

  twist_ring_decode #(.STAGES(4)) dut_i (
    .clk(clk), .rst(rst), .en(en), .state(st4), .hot(hot4));
  twist_ring_decode #(.STAGES(5)) dut5_i (
    .clk(clk), .rst(rst), .en(en), .state(st5), .hot(hot5));

  function automatic int exp_state(int n, int k);
    if (k <= n) return ((1 << k) - 1) << (n - k);
    return (1 << (2 * n - k)) - 1;
  endfunction

  function automatic bit is_legal(int n, int v);
    int c = 0;
    for (int i = 0; i < n - 1; i++)
      if (((v >> i) & 1) != ((v >> (i + 1)) & 1)) c++;
    return c <= 1;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic verify_all();
    chk(int'(st4) == exp_state(4, k4), "R2 R3 state N4", int'(st4), exp_state(4, k4));
    chk(int'(hot4) == (1 << k4), "R5 R6 hot N4", int'(hot4), 1 << k4);
    chk(int'(st5) == exp_state(5, k5), "R7 state N5", int'(st5), exp_state(5, k5));
    chk(int'(hot5) == (1 << k5), "R7 R6 hot N5", int'(hot5), 1 << k5);
    chk(is_legal(4, int'(st4)) && is_legal(5, int'(st5)), "R8 legal", int'(st4), int'(st4));
  endtask

  task automatic step(bit e);
    logic [3:0] prev4 = st4;
    en = e;
    @(posedge clk);
    #1;
    if (e) begin
      k4 = (k4 + 1) % 8;
      k5 = (k5 + 1) % 10;
    end else begin
      chk(st4 == prev4, "R4 hold", int'(st4), int'(prev4));
    end
    verify_all();
  endtask

  initial begin
    #(200000 * 4);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    lf = 16'hACE1;
    @(posedge clk); @(posedge clk); #1;
    chk(st4 == 4'b0000, "R1 reset state", int'(st4), 0);
    chk(hot4 == 8'h01, "R1 reset hot", int'(hot4), 1);
    rst = 0;
    for (int i = 0; i < 8; i++) begin
      step(1);
    end
    chk(st4 == 4'b0000, "R3 period 8", int'(st4), 0);
    for (int i = 0; i < 3; i++) step(0);
    for (int i = 0; i < 400; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[0] | lf[3]);
    end
    for (int i = 0; i < 3; i++) step(1);
    rst = 1; en = 1;
    @(posedge clk); #1;
    k4 = 0; k5 = 0;
    chk(st4 == 4'b0000 && st5 == 5'b0, "R1 mid reset", int'(st4), 0);
    chk(hot5 == 10'h001, "R1 mid reset hot", int'(hot5), 1);
    rst = 0;
    for (int i = 0; i < 25; i++) step(1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule